// File: doc/BRIEF.md
# Link Controller Interrupt Register Pair

This block holds the interrupt status and interrupt enable bytes of a serial link controller. Single-cycle event pulses come in from the ring engine and the FIFOs. Each pulse sets a sticky status bit. The block drives one level-sensitive interrupt line that stays high while any pending status bit has its enable bit set.

Software reaches both registers through a plain 8-bit port with a byte address. Reads are combinational. A write lands on the next clock edge.

The two registers use the same bit layout. Writing a one to a status bit clears that bit. The enable register is an ordinary read/write byte. The three lowest bits of both registers always read back as ones. A transmit-done pulse counts only when the finished transmit slot asked for an interrupt.

Top module: `link_irq_regs`

## Requirements
- R1: After reset, both the status and the enable registers read 0x07, and `irq` is low.
- R2: An event pulse sets its status bit on the next clock edge. The bits are: bit 7 transmit done, bit 6 receive done, bit 5 transmit underrun, bit 4 receive overflow, bit 3 serial gap received. Several pulses in one cycle set all of their bits.
- R3: Bits 2..0 read as 1 at the status address (0x0C) and at the enable address (0x0D).
- R4: Writing to the status address clears each status bit whose write-data bit is 1. Bits whose write-data bit is 0 keep their value.
- R5: A transmit-done pulse sets bit 7 only when `tx_slot_irq` is high in the same cycle.
- R6: A write to the enable address loads write-data bits 7..3 into the enable register, both ones and zeros.
- R7: `irq` is high exactly when some status bit and the matching enable bit are both 1.
- R8: If an event pulse and a clearing write hit the same status bit in one cycle, the bit ends up set.
- R9: Status bits latch even while their source is disabled. Enabling a source that has a pending bit raises `irq` at once.
- R10: Writes to any address other than 0x0C or 0x0D change neither register. Reads of such addresses return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 5 | Byte address of the register access |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| ev_tx_done | input | 1 | Transmit slot finished pulse |
| tx_slot_irq | input | 1 | Finished slot requested an interrupt |
| ev_rx_done | input | 1 | Receive finished pulse |
| ev_tx_under | input | 1 | Transmit FIFO underrun pulse |
| ev_rx_over | input | 1 | Receive FIFO overflow pulse |
| ev_gap | input | 1 | Serial gap received pulse |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions assume the event inputs and the write strobe are clean synchronous signals. They also assume `tx_slot_irq` is meaningful only alongside `ev_tx_done`, so a set or clear in one cycle can be judged from the inputs sampled in that cycle. The stimulus changes inputs just after a rising edge and holds each event or write for exactly one cycle. It raises events and clearing writes together only in the deliberate collision case. Reads are made in idle cycles, so that no pending write or event changes the value under observation.

// File: rtl/link_irq_regs.sv
module link_irq_regs #(
  parameter int          AW        = 5,
  parameter logic [AW-1:0] STAT_ADDR = 5'h0C,
  parameter logic [AW-1:0] EN_ADDR   = 5'h0D
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  input  logic          ev_tx_done,
  input  logic          tx_slot_irq,
  input  logic          ev_rx_done,
  input  logic          ev_tx_under,
  input  logic          ev_rx_over,
  input  logic          ev_gap,
  output logic          irq
);
  localparam int NSRC = 5;
  localparam int LOW  = 8 - NSRC;

  logic [NSRC-1:0] stat_q, en_q, set_v, clr_v;
  logic            hit_stat, hit_en;

  assign hit_stat = (addr == STAT_ADDR);
  assign hit_en   = (addr == EN_ADDR);

  assign set_v = {ev_tx_done & tx_slot_irq, ev_rx_done, ev_tx_under, ev_rx_over, ev_gap};
  assign clr_v = (wr_en && hit_stat) ? wdata[7:LOW] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= '0;
    end else begin
      stat_q <= (stat_q & ~clr_v) | set_v;
      if (wr_en && hit_en) en_q <= wdata[7:LOW];
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (hit_stat)    rdata = {stat_q, {LOW{1'b1}}};
    else if (hit_en) rdata = {en_q, {LOW{1'b1}}};
  end

  assign irq = |(stat_q & en_q);
endmodule

module link_irq_regs_chk #(
  parameter int          AW        = 5,
  parameter logic [AW-1:0] STAT_ADDR = 5'h0C,
  parameter logic [AW-1:0] EN_ADDR   = 5'h0D
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic          wr_en,
  input logic [7:0]    wdata,
  input logic [7:0]    rdata,
  input logic          ev_tx_done,
  input logic          tx_slot_irq,
  input logic          ev_rx_done,
  input logic          irq,
  input logic [4:0]    stat_q,
  input logic [4:0]    en_q
);
  logic clr_wr, en_wr;
  assign clr_wr = wr_en && (addr == STAT_ADDR);
  assign en_wr  = wr_en && (addr == EN_ADDR);

  a_r2_rx_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_done |=> stat_q[3]);

  a_r3_low_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == STAT_ADDR || addr == EN_ADDR) |-> rdata[2:0] == 3'b111);

  a_r4_clear_rx_done: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && wdata[6] && !ev_rx_done) |=> !stat_q[3]);

  a_r5_tx_done_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_q[4] && !(ev_tx_done && tx_slot_irq)) |=> !stat_q[4]);

  a_r6_enable_load: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr |=> en_q == $past(wdata[7:3]));

  a_r7_irq_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stat_q != 5'd0 && en_q != 5'd0));

  a_r8_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && wdata[7] && ev_tx_done && tx_slot_irq) |=> stat_q[4]);
endmodule

bind link_irq_regs link_irq_regs_chk #(.AW(AW), .STAT_ADDR(STAT_ADDR), .EN_ADDR(EN_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
  .ev_tx_done(ev_tx_done), .tx_slot_irq(tx_slot_irq), .ev_rx_done(ev_rx_done),
  .irq(irq), .stat_q(stat_q), .en_q(en_q)
);

// File: tb/link_irq_regs_tb.sv
module link_irq_regs_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       ev_tx_done = 0, tx_slot_irq = 0, ev_rx_done = 0;
  logic       ev_tx_under = 0, ev_rx_over = 0, ev_gap = 0;
  logic       irq;

  int checks = 0, errors = 0;
  logic probe = 1'b0;
  logic probe_irq = 1'b0;
  int   exp_q[$];
  string tag_q[$];
  bit   done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_irq_regs u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
    .ev_tx_done(ev_tx_done), .tx_slot_irq(tx_slot_irq), .ev_rx_done(ev_rx_done),
    .ev_tx_under(ev_tx_under), .ev_rx_over(ev_rx_over), .ev_gap(ev_gap), .irq(irq)
  );

  always @(negedge clk) begin
    if (probe && exp_q.size() > 0) begin
      int e;
      string t;
      int act;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      act = probe_irq ? int'(irq) : int'(rdata);
      checks++;
      if (act != e) begin
        errors++;
        $display("FAIL %s: actual 0x%02h expected 0x%02h", t, act, e);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic rd(input logic [4:0] a, input int e, input string t);
    addr = a; probe_irq = 0;
    exp_q.push_back(e); tag_q.push_back(t);
    probe = 1; tick(); probe = 0;
  endtask

  task automatic chk_irq(input int e, input string t);
    probe_irq = 1;
    exp_q.push_back(e); tag_q.push_back(t);
    probe = 1; tick(); probe = 0; probe_irq = 0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1; tick(); wr_en = 0;
  endtask

  task automatic pulse(input logic [4:0] m, input logic flag);
    {ev_tx_done, ev_rx_done, ev_tx_under, ev_rx_over, ev_gap} = m;
    tx_slot_irq = flag;
    tick();
    {ev_tx_done, ev_rx_done, ev_tx_under, ev_rx_over, ev_gap} = '0;
    tx_slot_irq = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(); tick(); rst_n = 1; tick();
    rd(5'h0C, 8'h07, "R1 status after reset");
    rd(5'h0D, 8'h07, "R1 R3 enable after reset");
    chk_irq(0, "R1 irq after reset");

    pulse(5'b00001, 0);
    rd(5'h0C, 8'h0F, "R2 gap bit3");
    chk_irq(0, "R9 latched while disabled");
    wr(5'h0D, 8'h08);
    chk_irq(1, "R9 enable pending source");
    rd(5'h0D, 8'h0F, "R6 enable readback");

    wr(5'h0C, 8'h08);
    rd(5'h0C, 8'h07, "R4 clear gap");
    chk_irq(0, "R7 irq drops after clear");

    pulse(5'b10000, 0);
    rd(5'h0C, 8'h07, "R5 tx done without slot flag");
    pulse(5'b10000, 1);
    rd(5'h0C, 8'h87, "R2 R5 tx done with slot flag");

    pulse(5'b01110, 0);
    rd(5'h0C, 8'hF7, "R2 simultaneous events");
    wr(5'h0C, 8'h00);
    rd(5'h0C, 8'hF7, "R4 zero write keeps bits");
    wr(5'h0C, 8'h40);
    rd(5'h0C, 8'hB7, "R4 clear rx done only");

    wr(5'h0D, 8'hFF);
    rd(5'h0D, 8'hFF, "R6 all enabled");
    chk_irq(1, "R7 irq with enabled pending");
    wr(5'h0D, 8'h00);
    rd(5'h0D, 8'h07, "R6 zeros disable");
    chk_irq(0, "R7 pending but disabled");
    wr(5'h0D, 8'h20);
    chk_irq(1, "R7 underrun enabled");

    addr = 5'h0C; wdata = 8'h80; wr_en = 1;
    ev_tx_done = 1; tx_slot_irq = 1;
    tick();
    wr_en = 0; ev_tx_done = 0; tx_slot_irq = 0;
    rd(5'h0C, 8'hB7, "R8 event beats clear");

    wr(5'h05, 8'hFF);
    rd(5'h0C, 8'hB7, "R10 stray write status");
    rd(5'h0D, 8'h27, "R10 stray write enable");
    rd(5'h05, 8'h00, "R10 stray read");

    tick();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule